// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block finds the first PHY that answers on a shared management bus. After a start pulse it probes each PHY address in turn by asking an attached management-frame master for a register read. It uses a single request/acknowledge handshake and keeps only one read in flight. An address whose reply to the low identifier register is all ones counts as empty. The first address that gives any other reply ends the scan. The block then reads the high identifier register at that address and puts the two replies together into a 32-bit identifier.

A PHY that is still coming out of reset may not answer on the first sweep. For that reason the block repeats the full address sweep up to a set number of passes, with a wait of a set number of clock cycles between passes and no wait before the first. When it finishes it raises a one-cycle done pulse. It reports either the found address and the identifier, or a not-found result. These outputs keep their values until the next accepted start.

Top module: `phy_probe_scan`

## Requirements
- R1: After reset the block is idle: mgmtReq, busy, done and found are 0, foundAddr is all ones (31) and phyId is 0.
- R2: A start pulse seen while idle makes busy and mgmtReq go high in the next cycle. That first request has mgmtPhy = 0 and mgmtReg = 3.
- R3: Within a pass, addresses go 0, 1, ... 31 in ascending order. While mgmtReq is high and mgmtAck has not come, mgmtReq, mgmtPhy and mgmtReg stay stable. A request with the next address may start in the cycle right after an acknowledge.
- R4: A reply of 0xFFFF to the register-3 read marks the address as empty, and the scan moves on to the next address.
- R5: The first register-3 reply that is not 0xFFFF stops the sweep. The block then reads register 2 at the same address. At the end, phyId[31:16] holds the register-2 reply, phyId[15:0] holds the register-3 reply, found = 1 and foundAddr holds that address.
- R6: After a pass that finds nothing, mgmtReq stays low for exactly WAIT_CYCLES cycles, and then the next pass starts again at address 0.
- R7: At most MAX_PASSES passes are made. If none of them finds a device, the block ends with found = 0, foundAddr = all ones and phyId = 0.
- R8: done is high for exactly one cycle, the cycle after the final acknowledge. From that same cycle on, busy is low.
- R9: A start pulse that arrives while busy has no effect on the scan or on its results.
- R10: The result outputs hold their values while idle until the next accepted start. An accepted start clears them to the not-found values of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a discovery run when idle |
| mgmtReq | output | 1 | Read request to the management master |
| mgmtPhy | output | 5 | PHY address of the request |
| mgmtReg | output | 5 | Register address of the request |
| mgmtAck | input | 1 | Read completed; mgmtData is valid |
| mgmtData | input | 16 | Read reply |
| busy | output | 1 | A discovery run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| found | output | 1 | A device was found |
| foundAddr | output | 5 | Address of the found device, all ones if none |
| phyId | output | 32 | Assembled identifier |

## Verification
A start sampled at a clock edge puts the first request on the bus in the cycle that follows. An acknowledge sampled at an edge gives the next request, or the start of the pause, or the done pulse with its final results, one cycle after that edge. A pause keeps the request line low for exactly WAIT_CYCLES cycles. The bench keeps a behavioural model that is advanced at every rising edge from the same start, acknowledge and reply values the design receives. It compares all outputs at every falling edge, so each result is checked in exactly the cycle it is due. The responder varies its acknowledge latency, and so the timing checks also cover slow replies.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE,
    ST_IDENT,
    ST_PAUSE
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearRes;
    logic scanInit;
    logic addrNext;
    logic passNext;
    logic pauseClr;
    logic pauseTick;
    logic loadLow;
    logic loadHigh;
  } scanCtrl_t;

endpackage

// File: rtl/phy_scan_dp.sv
module phy_scan_dp
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int MAX_PASSES  = 11,
  parameter int WAIT_CYCLES = 1000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  scanCtrl_t           ctrl,
  input  logic [DATA_W-1:0]   ackData,
  output logic [ADDR_W-1:0]   curAddr,
  output logic                addrLast,
  output logic                passLast,
  output logic                pauseDone,
  output logic                replyEmpty,
  output logic                found,
  output logic [ADDR_W-1:0]   foundAddr,
  output logic [2*DATA_W-1:0] phyId
);

  localparam int PASS_W = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1;
  localparam int WAIT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [PASS_W-1:0] PASS_END = PASS_W'(MAX_PASSES - 1);
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(WAIT_CYCLES - 1);

  logic [PASS_W-1:0] passCnt;
  logic [WAIT_W-1:0] pauseCnt;

  assign addrLast   = (curAddr == '1);
  assign passLast   = (passCnt == PASS_END);
  assign pauseDone  = (pauseCnt == WAIT_END);
  assign replyEmpty = (ackData == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      passCnt <= '0;
    end else begin
      if (ctrl.scanInit) begin
        curAddr <= '0;
        passCnt <= '0;
      end else if (ctrl.passNext) begin
        curAddr <= '0;
        passCnt <= passCnt + 1'b1;
      end else if (ctrl.addrNext) begin
        curAddr <= curAddr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseCnt <= '0;
    end else if (ctrl.pauseClr) begin
      pauseCnt <= '0;
    end else if (ctrl.pauseTick) begin
      pauseCnt <= pauseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearRes) begin
      found     <= 1'b0;
      foundAddr <= '1;
      phyId     <= '0;
    end else begin
      if (ctrl.loadLow) begin
        phyId[DATA_W-1:0] <= ackData;
        foundAddr         <= curAddr;
      end
      if (ctrl.loadHigh) begin
        phyId[2*DATA_W-1:DATA_W] <= ackData;
        found                    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/phy_scan_ctrl.sv
module phy_scan_ctrl
  import phy_scan_pkg::*;
#(
  parameter int          REG_W      = 5,
  parameter logic [4:0]  ID_LO_REG  = 5'd3,
  parameter logic [4:0]  ID_HI_REG  = 5'd2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             ack,
  input  logic             addrLast,
  input  logic             passLast,
  input  logic             pauseDone,
  input  logic             replyEmpty,
  output scanCtrl_t        ctrl,
  output logic             req,
  output logic [REG_W-1:0] regSel,
  output logic             busy,
  output logic             done
);

  scanState_t state, stateNext;
  logic       doneNext;

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.clearRes = 1'b1;
          ctrl.scanInit = 1'b1;
          stateNext     = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (ack) begin
          if (!replyEmpty) begin
            ctrl.loadLow = 1'b1;
            stateNext    = ST_IDENT;
          end else if (!addrLast) begin
            ctrl.addrNext = 1'b1;
          end else if (passLast) begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end else begin
            ctrl.pauseClr = 1'b1;
            stateNext     = ST_PAUSE;
          end
        end
      end
      ST_IDENT: begin
        if (ack) begin
          ctrl.loadHigh = 1'b1;
          stateNext     = ST_IDLE;
          doneNext      = 1'b1;
        end
      end
      ST_PAUSE: begin
        if (pauseDone) begin
          ctrl.passNext = 1'b1;
          stateNext     = ST_PROBE;
        end else begin
          ctrl.pauseTick = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign req    = (state == ST_PROBE) || (state == ST_IDENT);
  assign regSel = (state == ST_IDENT) ? REG_W'(ID_HI_REG) : REG_W'(ID_LO_REG);
  assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/phy_probe_scan.sv
module phy_probe_scan
  import phy_scan_pkg::*;
#(
  parameter int MAX_PASSES  = 11,
  parameter int WAIT_CYCLES = 1000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        mgmtReq,
  output logic [4:0]  mgmtPhy,
  output logic [4:0]  mgmtReg,
  input  logic        mgmtAck,
  input  logic [15:0] mgmtData,
  output logic        busy,
  output logic        done,
  output logic        found,
  output logic [4:0]  foundAddr,
  output logic [31:0] phyId
);

  localparam int ADDR_W = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  scanCtrl_t ctrl;
  logic      addrLast, passLast, pauseDone, replyEmpty;
  logic      ackSeen;

  assign ackSeen = mgmtAck & mgmtReq;

  phy_scan_ctrl #(
    .REG_W    (REG_W),
    .ID_LO_REG(5'd3),
    .ID_HI_REG(5'd2)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .ack       (ackSeen),
    .addrLast  (addrLast),
    .passLast  (passLast),
    .pauseDone (pauseDone),
    .replyEmpty(replyEmpty),
    .ctrl      (ctrl),
    .req       (mgmtReq),
    .regSel    (mgmtReg),
    .busy      (busy),
    .done      (done)
  );

  phy_scan_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAX_PASSES (MAX_PASSES),
    .WAIT_CYCLES(WAIT_CYCLES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .ackData   (mgmtData),
    .curAddr   (mgmtPhy),
    .addrLast  (addrLast),
    .passLast  (passLast),
    .pauseDone (pauseDone),
    .replyEmpty(replyEmpty),
    .found     (found),
    .foundAddr (foundAddr),
    .phyId     (phyId)
  );

endmodule

// File: rtl/phy_probe_scan_chk.sv
module phy_probe_scan_chk #(
  parameter int WAIT_CYCLES = 1000000
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        mgmtReq,
  input logic [4:0]  mgmtPhy,
  input logic [4:0]  mgmtReg,
  input logic        mgmtAck,
  input logic        busy,
  input logic        done,
  input logic        found,
  input logic [4:0]  foundAddr,
  input logic [31:0] phyId
);

  int gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= 0;
    else if (busy && !mgmtReq) gapCnt <= gapCnt + 1;
    else gapCnt <= 0;
  end

  p_start_probe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && mgmtReq && mgmtPhy == 5'd0 && mgmtReg == 5'd3));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtReq && !mgmtAck) |=> (mgmtReq && $stable(mgmtPhy) && $stable(mgmtReg)));

  p_req_in_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    mgmtReq |-> busy);

  p_id_low_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> (phyId[15:0] != 16'hFFFF));

  p_pause_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !mgmtReq) |-> (gapCnt < WAIT_CYCLES));

  p_miss_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !found) |-> (foundAddr == 5'h1F && phyId == 32'd0));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(found) && $stable(foundAddr) && $stable(phyId)));

endmodule

bind phy_probe_scan phy_probe_scan_chk #(.WAIT_CYCLES(WAIT_CYCLES)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .mgmtReq  (mgmtReq),
  .mgmtPhy  (mgmtPhy),
  .mgmtReg  (mgmtReg),
  .mgmtAck  (mgmtAck),
  .busy     (busy),
  .done     (done),
  .found    (found),
  .foundAddr(foundAddr),
  .phyId    (phyId)
);

// File: tb/test_phy_probe_scan.sv
`timescale 1ns/1ps
module test_phy_probe_scan;

  localparam int PASSES = 11;
  localparam int WAITC  = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        mgmtReq;
  logic [4:0]  mgmtPhy;
  logic [4:0]  mgmtReg;
  logic        mgmtAck = 1'b0;
  logic [15:0] mgmtData = 16'h0;
  logic        busy, done, found;
  logic [4:0]  foundAddr;
  logic [31:0] phyId;

  int checks = 0;
  int errors = 0;
  int cycle = 0;

  // responder settings
  logic [31:0] presentMask = 32'h0;
  int          wakeCycle = 0;
  int          lat = 0;
  int          rspCnt = 0;
  logic        lowZero = 1'b0;
  int          addr0Probes = 0;
  int          pauseCycles = 0;

  // reference model state
  int          mPhase = 0;   // 0 idle, 1 low-id probe, 2 high-id read, 3 pause
  int          mAddr = 0;
  int          mPass = 0;
  int          mWait = 0;
  logic        mDone = 1'b0;
  logic        mFound = 1'b0;
  logic [4:0]  mFoundAddr = 5'h1F;
  logic [31:0] mId = 32'h0;

  always #5 clk = ~clk;

  phy_probe_scan #(.MAX_PASSES(PASSES), .WAIT_CYCLES(WAITC)) i_phy_probe_scan (
    .clk(clk), .rstN(rstN), .start(start),
    .mgmtReq(mgmtReq), .mgmtPhy(mgmtPhy), .mgmtReg(mgmtReg),
    .mgmtAck(mgmtAck), .mgmtData(mgmtData),
    .busy(busy), .done(done), .found(found),
    .foundAddr(foundAddr), .phyId(phyId)
  );

  function automatic logic [15:0] lowWord(int a);
    return lowZero ? 16'h0000 : 16'h1200 + 16'(a);
  endfunction

  function automatic logic [15:0] highWord(int a);
    return 16'hA500 + 16'(a);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    cycle++;
    if (!rstN) begin
      mPhase = 0; mAddr = 0; mPass = 0; mWait = 0; mDone = 1'b0;
      mFound = 1'b0; mFoundAddr = 5'h1F; mId = 32'h0;
    end else begin
      mDone = 1'b0;
      case (mPhase)
        0: if (start) begin
             mPhase = 1; mAddr = 0; mPass = 0;
             mFound = 1'b0; mFoundAddr = 5'h1F; mId = 32'h0;
           end
        1: if (mgmtAck) begin
             if (mgmtData != 16'hFFFF) begin
               mId[15:0] = mgmtData; mFoundAddr = 5'(mAddr); mPhase = 2;
             end else if (mAddr == 31) begin
               if (mPass == PASSES - 1) begin mPhase = 0; mDone = 1'b1; end
               else begin mPhase = 3; mWait = 0; end
             end else mAddr++;
           end
        2: if (mgmtAck) begin
             mId[31:16] = mgmtData; mFound = 1'b1; mPhase = 0; mDone = 1'b1;
           end
        default: if (mWait == WAITC - 1) begin
             mPhase = 1; mAddr = 0; mPass++;
           end else mWait++;
      endcase
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic expReq;
      expReq = (mPhase == 1) || (mPhase == 2);
      check("R3", "request line", {31'd0, mgmtReq}, {31'd0, expReq});
      if (expReq) begin
        check("R3", "request address", {27'd0, mgmtPhy}, 32'(mAddr));
        check("R5", "request register", {27'd0, mgmtReg}, (mPhase == 1) ? 32'd3 : 32'd2);
      end
      check("R2", "busy", {31'd0, busy}, {31'd0, mPhase != 0});
      check("R8", "done", {31'd0, done}, {31'd0, mDone});
      check("R10", "found", {31'd0, found}, {31'd0, mFound});
      check("R10", "foundAddr", {27'd0, foundAddr}, {27'd0, mFoundAddr});
      check("R10", "phyId", phyId, mId);
    end
  end

  // management responder
  always @(negedge clk) begin
    if (!rstN) begin
      mgmtAck <= 1'b0; rspCnt = 0;
    end else if (mgmtAck) begin
      mgmtAck <= 1'b0; rspCnt = 0;
    end else if (mgmtReq) begin
      if (rspCnt >= lat) begin
        mgmtAck <= 1'b1;
        if (mgmtPhy == 5'd0 && mgmtReg == 5'd3) addr0Probes++;
        if (presentMask[mgmtPhy] && cycle >= wakeCycle)
          mgmtData <= (mgmtReg == 5'd3) ? lowWord(int'(mgmtPhy)) : highWord(int'(mgmtPhy));
        else
          mgmtData <= 16'hFFFF;
      end else rspCnt++;
    end
    if (rstN && busy && !mgmtReq) pauseCycles++;
  end

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(string req);
    int n = 0;
    while (done !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin
      errors++;
      $display("FAIL %s watchdog: no done, actual 0 expected 1", req);
    end
  endtask

  task automatic runScan(logic [31:0] mask, int wakeDelay, int latency, string req);
    presentMask = mask; wakeCycle = cycle + wakeDelay; lat = latency;
    addr0Probes = 0; pauseCycles = 0;
    pulseStart();
    waitDone(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset req", {31'd0, mgmtReq}, 32'd0);
    check("R1", "reset busy", {31'd0, busy}, 32'd0);
    check("R1", "reset done", {31'd0, done}, 32'd0);
    check("R1", "reset found", {31'd0, found}, 32'd0);
    check("R1", "reset foundAddr", {27'd0, foundAddr}, 32'h1F);
    check("R1", "reset phyId", phyId, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R5: single device at address 5, immediate replies
    runScan(32'h0000_0020, 0, 0, "R5");
    check("R5", "found", {31'd0, found}, 32'd1);
    check("R5", "foundAddr", {27'd0, foundAddr}, 32'd5);
    check("R5", "phyId", phyId, {highWord(5), lowWord(5)});

    // R10: results hold while idle
    repeat (6) @(negedge clk);
    check("R10", "held foundAddr", {27'd0, foundAddr}, 32'd5);
    check("R10", "held phyId", phyId, {highWord(5), lowWord(5)});

    // R3 R4: two devices, lowest address wins, slow replies
    runScan(32'h0000_0208, 0, 2, "R3");
    check("R3", "lowest address", {27'd0, foundAddr}, 32'd3);
    check("R5", "phyId two devices", phyId, {highWord(3), lowWord(3)});

    // R3: device at the top address
    runScan(32'h8000_0000, 0, 1, "R3");
    check("R3", "top address", {27'd0, foundAddr}, 32'd31);
    check("R6", "no pause in one pass", 32'(pauseCycles), 32'd0);

    // R5: low identifier word of zero still counts as present
    lowZero = 1'b1;
    runScan(32'h0000_0080, 0, 0, "R5");
    check("R5", "zero low word addr", {27'd0, foundAddr}, 32'd7);
    check("R5", "zero low word id", phyId, {highWord(7), 16'h0000});
    lowZero = 1'b0;

    // R6: device wakes during the third pass
    runScan(32'h0000_0001, 150, 0, "R6");
    check("R6", "late device found", {31'd0, found}, 32'd1);
    check("R6", "late device addr", {27'd0, foundAddr}, 32'd0);
    check("R6", "pause cycles", 32'(pauseCycles), 32'((addr0Probes - 1) * WAITC));

    // R7: nothing present on any pass
    runScan(32'h0, 0, 0, "R7");
    check("R7", "pass count", 32'(addr0Probes), 32'(PASSES));
    check("R7", "not found", {31'd0, found}, 32'd0);
    check("R7", "invalid addr", {27'd0, foundAddr}, 32'h1F);
    check("R7", "cleared id", phyId, 32'd0);
    check("R6", "total pause", 32'(pauseCycles), 32'((PASSES - 1) * WAITC));

    // R9: start pulses during a run are ignored
    presentMask = 32'h0000_1000; wakeCycle = cycle; lat = 1;
    pulseStart();
    repeat (10) @(negedge clk);
    pulseStart();
    repeat (5) @(negedge clk);
    pulseStart();
    waitDone("R9");
    check("R9", "busy start ignored addr", {27'd0, foundAddr}, 32'd12);
    check("R9", "busy start ignored id", phyId, {highWord(12), lowWord(12)});
    @(negedge clk);
    check("R8", "done one cycle", {31'd0, done}, 32'd0);
    check("R8", "idle after done", {31'd0, busy}, 32'd0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule